// File: doc/BRIEF.md
# Sensor Scratchpad Command Controller

This block is the byte-level function layer of a single-wire temperature sensor slave. It takes over once device selection has completed. A bit-layer front end hands it each received byte as a strobe. The front end also raises a one-cycle strobe for each master read slot and expects one response bit back. The block decodes the function command that opens each session. It keeps the scratchpad registers and a staged nonvolatile copy of the alarm limits and configuration. It also issues request pulses to the conversion engine and to the nonvolatile writer.

A session opens with one command byte and ends at the next bus reset strobe. Write-scratchpad takes three bytes. Read-scratchpad shifts out eight register bytes and then a CRC byte, one bit per read slot. Convert and copy start an operation and then report its progress on read slots. Power-query reports the supply scheme.

Top module: `scratchpad_cmd_ctrl`

## Requirements
- R1: After rst_ni is released, the temperature bytes hold 0550h. The high limit, low limit and configuration copies and the nonvolatile outputs hold 4Bh, 46h and 7Fh. No request pulse is raised.
- R2: Command 4Eh stores the next three data bytes as high limit, low limit and configuration, in that order. Any further bytes in the same session have no effect.
- R3: A bus reset strobe ends any command. Bytes already written by a cut-off 4Eh are kept. The next byte is decoded as a new command.
- R4: Command BEh returns one bit per read slot, least significant bit first. Bytes come in this order: temperature low, temperature high, high limit, low limit, configuration, then FFh, 0Ch and 10h. A ninth byte follows: the CRC over the first eight bytes, using polynomial x^8+x^5+x^4+1 (reflected 8Ch), initial value 0, bits fed LSB first. Slots after the ninth byte return 1.
- R5: Command 44h raises conv_req_o for exactly one cycle, in the cycle after the command byte is accepted.
- R6: On conv_done_i during a conversion, the temperature takes temp_i with low bits cleared according to configuration bits 6:5. 00 clears bits 2:0, 01 clears bits 1:0, 10 clears bit 0, and 11 keeps all bits.
- R7: Command 48h raises copy_req_o for one cycle and captures the three scratchpad copies. The nonvolatile outputs take the captured values only on copy_done_i and are unchanged otherwise.
- R8: After 44h or 48h, read slots return 0 while the operation is in progress. They return 1 once it has completed.
- R9: After command B4h, read slots return ext_pwr_i: 0 for parasite supply, 1 for external supply.
- R10: An unrecognised command byte has no effect. The bytes that follow in the same session are ignored, and read slots return 1.
- R11: rd_valid_o is high for exactly the cycle after each rd_slot_i strobe, with rd_bit_o valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| bus_rst_i | input | 1 | Bus reset strobe, ends the session |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rd_slot_i | input | 1 | Master read slot strobe |
| rd_valid_o | output | 1 | Response bit valid |
| rd_bit_o | output | 1 | Response bit |
| ext_pwr_i | input | 1 | 1 when externally powered |
| conv_req_o | output | 1 | Conversion request pulse |
| conv_done_i | input | 1 | Conversion finished strobe |
| temp_i | input | 16 | Raw conversion result |
| copy_req_o | output | 1 | Nonvolatile copy request pulse |
| copy_done_i | input | 1 | Nonvolatile copy finished strobe |
| nv_th_o | output | 8 | Stored high limit |
| nv_tl_o | output | 8 | Stored low limit |
| nv_cfg_o | output | 8 | Stored configuration |

## Verification
The bench cuts a write session short with a bus reset. A design that cleared the partial data, or that kept counting bytes into the next session, would read back the wrong limits. Every resolution code is converted. A wrong mask would leave stray fraction bits or drop significant ones. The copy test writes new scratchpad values while a copy is in flight, so a design that copied at completion time instead of at request time would store the newer values. Reads past the CRC byte, unknown commands and busy polling catch designs that leak stale bits or report completion too early.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_WR, ST_RD, ST_STAT, ST_PWR, ST_IDLE
  } sp_state_e;

  localparam logic [7:0] CMD_WR   = 8'h4E;
  localparam logic [7:0] CMD_RD   = 8'hBE;
  localparam logic [7:0] CMD_COPY = 8'h48;
  localparam logic [7:0] CMD_CONV = 8'h44;
  localparam logic [7:0] CMD_PWR  = 8'hB4;
  localparam logic [7:0] CRC_POLY = 8'h8C;
endpackage

// File: rtl/sp_crc8.sv
module sp_crc8 #(
  parameter int NBYTES = 8,
  localparam int NBITS = NBYTES * 8
) (
  input  logic [NBITS-1:0] data_i,
  output logic [7:0]       crc_o
);
  import sp_pkg::*;
  always_comb begin
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = 0; i < NBITS; i++) begin
      fb = c[0] ^ data_i[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY;
    end
    crc_o = c;
  end
endmodule

// File: rtl/sp_nv_store.sv
module sp_nv_store #(
  parameter logic [7:0] TH_INIT  = 8'h4B,
  parameter logic [7:0] TL_INIT  = 8'h46,
  parameter logic [7:0] CFG_INIT = 8'h7F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] th_i,
  input  logic [7:0] tl_i,
  input  logic [7:0] cfg_i,
  input  logic       done_i,
  output logic       req_o,
  output logic       busy_o,
  output logic [7:0] th_o,
  output logic [7:0] tl_o,
  output logic [7:0] cfg_o
);
  logic [7:0] th_p, tl_p, cfg_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      busy_o <= 1'b0;
      th_p   <= '0;
      tl_p   <= '0;
      cfg_p  <= '0;
      th_o   <= TH_INIT;
      tl_o   <= TL_INIT;
      cfg_o  <= CFG_INIT;
    end else begin
      req_o <= start_i;
      if (start_i) begin
        busy_o <= 1'b1;
        th_p   <= th_i;
        tl_p   <= tl_i;
        cfg_p  <= cfg_i;
      end else if (busy_o && done_i) begin
        // commit staged snapshot
        busy_o <= 1'b0;
        th_o   <= th_p;
        tl_o   <= tl_p;
        cfg_o  <= cfg_p;
      end
    end
  end
endmodule

// File: rtl/sp_conv.sv
module sp_conv #(
  parameter int          TW        = 16,
  parameter logic [TW-1:0] TEMP_INIT = 16'h0550
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          done_i,
  input  logic [TW-1:0] temp_i,
  input  logic [1:0]    res_i,
  output logic          req_o,
  output logic          busy_o,
  output logic [TW-1:0] temp_o
);
  logic [TW-1:0] keep_mask;

  always_comb begin
    keep_mask = '1;
    unique case (res_i)
      2'b00: keep_mask[2:0] = 3'b000;
      2'b01: keep_mask[2:0] = 3'b100;
      2'b10: keep_mask[2:0] = 3'b110;
      default: keep_mask[2:0] = 3'b111;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      busy_o <= 1'b0;
      temp_o <= TEMP_INIT;
    end else begin
      req_o <= start_i;
      if (start_i) begin
        busy_o <= 1'b1;
      end else if (busy_o && done_i) begin
        busy_o <= 1'b0;
        temp_o <= temp_i & keep_mask;
      end
    end
  end
endmodule

// File: rtl/scratchpad_cmd_ctrl.sv
module scratchpad_cmd_ctrl #(
  parameter logic [7:0]  TH_INIT   = 8'h4B,
  parameter logic [7:0]  TL_INIT   = 8'h46,
  parameter logic [7:0]  CFG_INIT  = 8'h7F,
  parameter logic [15:0] TEMP_INIT = 16'h0550,
  parameter logic [23:0] RSV_BYTES = 24'h100CFF,
  parameter int          WR_BYTES  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_rst_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        rd_slot_i,
  output logic        rd_valid_o,
  output logic        rd_bit_o,
  input  logic        ext_pwr_i,
  output logic        conv_req_o,
  input  logic        conv_done_i,
  input  logic [15:0] temp_i,
  output logic        copy_req_o,
  input  logic        copy_done_i,
  output logic [7:0]  nv_th_o,
  output logic [7:0]  nv_tl_o,
  output logic [7:0]  nv_cfg_o
);
  import sp_pkg::*;

  localparam int SP_BYTES = 8;
  localparam int RD_BITS  = (SP_BYTES + 1) * 8;
  localparam int IW       = $clog2(RD_BITS + 1);
  localparam int WW       = $clog2(WR_BYTES);

  sp_state_e   state_q;
  logic [WW-1:0] wcnt_q;
  logic [IW-1:0] ridx_q;
  logic [7:0]  th_q, tl_q, cfg_q;
  logic [15:0] temp_q;
  logic        conv_busy, copy_busy, busy;
  logic        conv_go, copy_go, cmd_ok;
  logic [SP_BYTES*8-1:0] sp_vec;
  logic [7:0]  crc;
  logic [RD_BITS-1:0] rd_vec;

  assign busy   = conv_busy | copy_busy;
  assign cmd_ok = (state_q == ST_CMD) && rx_valid_i && !bus_rst_i;
  assign conv_go = cmd_ok && (rx_byte_i == CMD_CONV) && !busy;
  assign copy_go = cmd_ok && (rx_byte_i == CMD_COPY) && !busy;

  assign sp_vec = {RSV_BYTES, cfg_q, tl_q, th_q, temp_q};
  assign rd_vec = {crc, sp_vec};

  sp_crc8 #(.NBYTES(SP_BYTES)) u_crc (
    .data_i (sp_vec),
    .crc_o  (crc)
  );

  sp_conv #(.TW(16), .TEMP_INIT(TEMP_INIT)) u_conv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(conv_go),
    .done_i (conv_done_i),
    .temp_i (temp_i),
    .res_i  (cfg_q[6:5]),
    .req_o  (conv_req_o),
    .busy_o (conv_busy),
    .temp_o (temp_q)
  );

  sp_nv_store #(.TH_INIT(TH_INIT), .TL_INIT(TL_INIT), .CFG_INIT(CFG_INIT)) u_nv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(copy_go),
    .th_i   (th_q),
    .tl_i   (tl_q),
    .cfg_i  (cfg_q),
    .done_i (copy_done_i),
    .req_o  (copy_req_o),
    .busy_o (copy_busy),
    .th_o   (nv_th_o),
    .tl_o   (nv_tl_o),
    .cfg_o  (nv_cfg_o)
  );

  // command sequencing and scratchpad writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      wcnt_q  <= '0;
      th_q    <= TH_INIT;
      tl_q    <= TL_INIT;
      cfg_q   <= CFG_INIT;
    end else if (bus_rst_i) begin
      state_q <= ST_CMD;
      wcnt_q  <= '0;
    end else if (rx_valid_i) begin
      unique case (state_q)
        ST_CMD: begin
          wcnt_q <= '0;
          unique case (rx_byte_i)
            CMD_WR:   state_q <= ST_WR;
            CMD_RD:   state_q <= ST_RD;
            CMD_COPY,
            CMD_CONV: state_q <= ST_STAT;
            CMD_PWR:  state_q <= ST_PWR;
            default:  state_q <= ST_IDLE;
          endcase
        end
        ST_WR: begin
          unique case (wcnt_q)
            WW'(0):  th_q  <= rx_byte_i;
            WW'(1):  tl_q  <= rx_byte_i;
            default: cfg_q <= rx_byte_i;
          endcase
          if (wcnt_q == WW'(WR_BYTES - 1)) state_q <= ST_IDLE;
          else wcnt_q <= wcnt_q + WW'(1);
        end
        default: ;
      endcase
    end
  end

  // read slot responses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ridx_q     <= '0;
      rd_valid_o <= 1'b0;
      rd_bit_o   <= 1'b1;
    end else begin
      rd_valid_o <= rd_slot_i;
      if (bus_rst_i) begin
        ridx_q <= '0;
      end else if (rd_slot_i) begin
        unique case (state_q)
          ST_RD: begin
            if (ridx_q < IW'(RD_BITS)) begin
              rd_bit_o <= rd_vec[ridx_q];
              ridx_q   <= ridx_q + IW'(1);
            end else begin
              rd_bit_o <= 1'b1;
            end
          end
          ST_STAT: rd_bit_o <= !busy;
          ST_PWR:  rd_bit_o <= ext_pwr_i;
          default: rd_bit_o <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_slot_i,
  input logic        rd_valid_o,
  input logic        conv_req_o,
  input logic        copy_req_o,
  input logic        conv_done_i,
  input logic        copy_done_i,
  input logic [7:0]  nv_th_o,
  input logic [7:0]  nv_tl_o,
  input logic [7:0]  nv_cfg_o,
  input logic [15:0] temp_q,
  input logic        conv_busy,
  input logic        copy_busy
);
  AST_CONV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o); // R5
  AST_COPY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_req_o |=> !copy_req_o); // R7
  AST_NV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !copy_done_i |=> $stable({nv_th_o, nv_tl_o, nv_cfg_o})); // R7
  AST_TEMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> $stable(temp_q)); // R6
  AST_BUSY_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && conv_busy) || !conv_req_o); // R8
  AST_COPY_BUSY_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_req_o |-> copy_busy); // R8
  AST_RD_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_slot_i |=> rd_valid_o); // R11
  AST_RD_VALID_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_slot_i |=> !rd_valid_o); // R11
endmodule

bind scratchpad_cmd_ctrl sp_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_slot_i  (rd_slot_i),
  .rd_valid_o (rd_valid_o),
  .conv_req_o (conv_req_o),
  .copy_req_o (copy_req_o),
  .conv_done_i(conv_done_i),
  .copy_done_i(copy_done_i),
  .nv_th_o    (nv_th_o),
  .nv_tl_o    (nv_tl_o),
  .nv_cfg_o   (nv_cfg_o),
  .temp_q     (temp_q),
  .conv_busy  (conv_busy),
  .copy_busy  (copy_busy)
);

// File: tb/sim_scratchpad_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_scratchpad_cmd_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_rst = 0, rx_valid = 0, rd_slot = 0, ext_pwr = 1;
  logic conv_done = 0, copy_done = 0;
  logic [7:0] rx_byte = '0;
  logic [15:0] temp_in = '0;
  logic rd_valid, rd_bit, conv_req, copy_req;
  logic [7:0] nv_th, nv_tl, nv_cfg;
  int n_run = 0, n_fail = 0;
  logic [7:0] sp [0:8];

  always #10 clk = ~clk;

  scratchpad_cmd_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .rx_valid_i(rx_valid),
    .rx_byte_i(rx_byte), .rd_slot_i(rd_slot), .rd_valid_o(rd_valid), .rd_bit_o(rd_bit),
    .ext_pwr_i(ext_pwr), .conv_req_o(conv_req), .conv_done_i(conv_done), .temp_i(temp_in),
    .copy_req_o(copy_req), .copy_done_i(copy_done), .nv_th_o(nv_th), .nv_tl_o(nv_tl),
    .nv_cfg_o(nv_cfg)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_of(input logic [7:0] b [0:8]);
    logic [7:0] c = 0, d;
    for (int k = 0; k < 8; k++) begin
      d = b[k];
      for (int j = 0; j < 8; j++) begin
        if ((c[0] ^ d[0]) == 1'b1) c = (c >> 1) ^ 8'h8C;
        else c = c >> 1;
        d = d >> 1;
      end
    end
    return c;
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic breset();
    @(negedge clk); bus_rst = 1;
    @(negedge clk); bus_rst = 0;
  endtask

  task automatic read_bit(output logic b);
    @(negedge clk); rd_slot = 1;
    @(negedge clk); rd_slot = 0;
    check(rd_valid === 1'b1, "R11 valid after slot", rd_valid, 1);
    b = rd_bit;
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic b;
    for (int i = 0; i < 8; i++) begin
      read_bit(b);
      v[i] = b;
    end
  endtask

  task automatic read_sp();
    breset();
    send(8'hBE);
    for (int i = 0; i < 9; i++) read_byte(sp[i]);
  endtask

  task automatic write_sp(input logic [7:0] th, input logic [7:0] tl, input logic [7:0] cfg);
    breset();
    send(8'h4E); send(th); send(tl); send(cfg);
  endtask

  task automatic check_sp(input logic [7:0] th, input logic [7:0] tl, input logic [7:0] cfg, input string req);
    check(sp[2] == th, req, sp[2], th);
    check(sp[3] == tl, req, sp[3], tl);
    check(sp[4] == cfg, req, sp[4], cfg);
  endtask

  task automatic t_reset();
    logic b;
    check(conv_req == 0 && copy_req == 0, "R1 no requests", {conv_req, copy_req}, 0);
    check({nv_th, nv_tl, nv_cfg} == 24'h4B467F, "R1 nv init", {nv_th, nv_tl, nv_cfg}, 24'h4B467F);
    read_sp();
    check({sp[1], sp[0]} == 16'h0550, "R1 temp init", {sp[1], sp[0]}, 16'h0550);
    check_sp(8'h4B, 8'h46, 8'h7F, "R1 copies init");
    check({sp[7], sp[6], sp[5]} == 24'h100CFF, "R4 reserved", {sp[7], sp[6], sp[5]}, 24'h100CFF);
    check(sp[8] == crc_of(sp), "R4 crc", sp[8], crc_of(sp));
    read_bit(b);
    check(b == 1'b1, "R4 past ninth byte", b, 1);
    @(negedge clk);
    check(rd_valid == 1'b0, "R11 valid one cycle", rd_valid, 0);
  endtask

  task automatic t_write();
    write_sp(8'h11, 8'h22, 8'h3F);
    send(8'h55);
    read_sp();
    check_sp(8'h11, 8'h22, 8'h3F, "R2 write and extra ignored");
    check(sp[8] == crc_of(sp), "R4 crc after write", sp[8], crc_of(sp));
  endtask

  task automatic t_partial();
    breset();
    send(8'h4E); send(8'hA5);
    read_sp();
    check_sp(8'hA5, 8'h22, 8'h3F, "R3 partial write kept");
  endtask

  task automatic t_convert();
    logic [7:0]  cfgs [0:3] = '{8'h1F, 8'h3F, 8'h5F, 8'h7F};
    logic [15:0] raw  [0:3] = '{16'h0197, 16'h0193, 16'h00A3, 16'hFF5F};
    logic [15:0] exp  [0:3] = '{16'h0190, 16'h0190, 16'h00A2, 16'hFF5F};
    logic b;
    for (int i = 0; i < 4; i++) begin
      write_sp(8'h11, 8'h22, cfgs[i]);
      breset();
      @(negedge clk); rx_valid = 1; rx_byte = 8'h44;
      @(negedge clk); rx_valid = 0;
      check(conv_req == 1'b1, "R5 conv_req raised", conv_req, 1);
      @(negedge clk);
      check(conv_req == 1'b0, "R5 conv_req one cycle", conv_req, 0);
      read_bit(b);
      check(b == 1'b0, "R8 busy during conversion", b, 0);
      @(negedge clk); conv_done = 1; temp_in = raw[i];
      @(negedge clk); conv_done = 0;
      read_bit(b);
      check(b == 1'b1, "R8 done after conversion", b, 1);
      read_sp();
      check({sp[1], sp[0]} == exp[i], "R6 resolution mask", {sp[1], sp[0]}, exp[i]);
    end
  endtask

  task automatic t_copy();
    logic b;
    write_sp(8'h12, 8'h34, 8'h5F);
    breset();
    @(negedge clk); rx_valid = 1; rx_byte = 8'h48;
    @(negedge clk); rx_valid = 0;
    check(copy_req == 1'b1, "R7 copy_req raised", copy_req, 1);
    read_bit(b);
    check(b == 1'b0, "R8 busy during copy", b, 0);
    check({nv_th, nv_tl, nv_cfg} == 24'h4B467F, "R7 nv unchanged before done", {nv_th, nv_tl, nv_cfg}, 24'h4B467F);
    write_sp(8'h99, 8'h88, 8'h1F);
    breset(); send(8'h48);
    @(negedge clk); copy_done = 1;
    @(negedge clk); copy_done = 0;
    check({nv_th, nv_tl, nv_cfg} == 24'h12345F, "R7 staged copy committed", {nv_th, nv_tl, nv_cfg}, 24'h12345F);
    read_bit(b);
    check(b == 1'b1, "R8 done after copy", b, 1);
  endtask

  task automatic t_power();
    logic b;
    ext_pwr = 0;
    breset(); send(8'hB4);
    read_bit(b);
    check(b == 1'b0, "R9 parasite", b, 0);
    ext_pwr = 1;
    read_bit(b);
    check(b == 1'b1, "R9 external", b, 1);
  endtask

  task automatic t_unknown();
    logic b;
    breset(); send(8'h99); send(8'h4E); send(8'h77);
    read_bit(b);
    check(b == 1'b1, "R10 unknown reads one", b, 1);
    read_sp();
    check_sp(8'h99, 8'h88, 8'h1F, "R10 unknown no effect");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_partial();
    t_convert();
    t_copy();
    t_power();
    t_unknown();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule